// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block maps a two-part logical address, a segment number paired with a displacement, onto a physical address. It uses an on-chip table of per-segment base and limit values. Configuration logic fills the table one entry at a time through a write port. It also programs a length register that says how many table entries are in use. Each translation request is a single-cycle valid pulse carrying the segment number and the displacement.

One cycle after a request is accepted, the block presents a result with a valid strobe. The result is either the translated address or a two-bit trap code. The segment number is checked against the length register first. Only a segment that passes this check has its displacement compared against the segment's limit. When both checks pass, the address is the segment base plus the displacement. Servicing a trap is left to the surrounding system.

Top module: `seg_translator`

## Requirements
- R1: After reset, outValid, outTrap and outPaddr are 0 and the length register is 0. Any request issued before the length register is written therefore traps with code 1.
- R2: outValid is 1 in exactly the cycle after each cycle in which reqValid is 1, and 0 in every other cycle.
- R3: A request whose segment number is greater than or equal to the length register value returns trap code 1 (bad segment).
- R4: A request whose segment number is in range but whose displacement is greater than or equal to that segment's limit returns trap code 2 (over limit). A limit of 0 makes every displacement trap.
- R5: When the segment number is out of range, the result is trap code 1 whatever the displacement is.
- R6: A request that passes both checks returns trap code 0 and outPaddr equal to base plus displacement, taken modulo 2^24.
- R7: Whenever a result carries a nonzero trap code, outPaddr is 0. Trap code 3 never appears.
- R8: A write to a table entry or to the length register affects only requests accepted in later cycles. A request accepted in the same cycle as the write still sees the old value.
- R9: Every table index works, including the last one (255), once the length register is set to 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEntryWe | input | 1 | Write one table entry |
| cfgIdx | input | 8 | Index of the entry to write |
| cfgBase | input | 24 | Base value to write |
| cfgLimit | input | 17 | Limit value to write |
| cfgLenWe | input | 1 | Write the length register |
| cfgLen | input | 9 | Number of valid entries (0 to 256) |
| reqValid | input | 1 | Translation request strobe |
| reqSeg | input | 8 | Segment number of the request |
| reqDisp | input | 16 | Displacement of the request |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outPaddr | output | 24 | Physical address; 0 when the result traps |
| outTrap | output | 2 | 0 = ok, 1 = bad segment, 2 = over limit |

## Verification
The table is loaded with a five-segment example map and checked against known legal and illegal translations. Displacements of exactly limit-1 and exactly limit separate a strict compare from an inclusive one. Other patterns cover a segment number equal to the length register, a request that fails both checks (to show which check wins), a base near the top of the address space (to show the sum wraps), and a zero limit. Requests that share a cycle with a table or length write show whether the new value leaks into that result. Back-to-back requests followed by idle cycles show that the result strobe tracks each request exactly.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_SEG   = 2'd1,
    TRAP_LIMIT = 2'd2
  } trapCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      tblWrite;
    logic      lenWrite;
    logic      capture;
    trapCode_e trapSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int IDX_W  = 8,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BASE_W-1:0] wrBase,
  input  logic [LIM_W-1:0]  wrLimit,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [BASE_W-1:0] rdBase,
  output logic [LIM_W-1:0]  rdLimit
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [BASE_W-1:0] baseArr  [ENTRIES];
  logic [LIM_W-1:0]  limitArr [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        baseArr[i]  <= '0;
        limitArr[i] <= '0;
      end
    end else if (wrEn) begin
      baseArr[wrIdx]  <= wrBase;
      limitArr[wrIdx] <= wrLimit;
    end
  end

  assign rdBase  = baseArr[rdIdx];
  assign rdLimit = limitArr[rdIdx];

  // R8: a written entry holds the written pair on the following cycle
  a_r8_entry_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (baseArr[$past(wrIdx)] == $past(wrBase)) &&
             (limitArr[$past(wrIdx)] == $past(wrLimit)));

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int DISP_W = 16,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEG_W-1:0]  cfgIdx,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [LIM_W-1:0]  cfgLimit,
  input  logic [SEG_W:0]    cfgLen,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [DISP_W-1:0] reqDisp,
  output logic              segInRange,
  output logic              dispInLimit,
  output logic [BASE_W-1:0] outPaddr,
  output logic [1:0]        outTrap
);
  localparam int LEN_W = SEG_W + 1;
  localparam int CMP_W = (DISP_W > LIM_W) ? DISP_W : LIM_W;

  logic [LEN_W-1:0]  lenReg;
  logic [BASE_W-1:0] segBase;
  logic [LIM_W-1:0]  segLimit;
  logic [BASE_W-1:0] sumAddr;

  seg_table #(
    .IDX_W (SEG_W),
    .BASE_W(BASE_W),
    .LIM_W (LIM_W)
  ) u_table (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobe.tblWrite),
    .wrIdx  (cfgIdx),
    .wrBase (cfgBase),
    .wrLimit(cfgLimit),
    .rdIdx  (reqSeg),
    .rdBase (segBase),
    .rdLimit(segLimit)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                lenReg <= '0;
    else if (strobe.lenWrite) lenReg <= cfgLen;
  end

  assign segInRange  = {1'b0, reqSeg} < lenReg;
  assign dispInLimit = CMP_W'(reqDisp) < CMP_W'(segLimit);
  assign sumAddr     = segBase + BASE_W'(reqDisp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPaddr <= '0;
      outTrap  <= TRAP_NONE;
    end else if (strobe.capture) begin
      outTrap  <= strobe.trapSel;
      outPaddr <= (strobe.trapSel == TRAP_NONE) ? sumAddr : '0;
    end
  end

  // R1: an empty table rejects every segment
  a_r1_empty_table: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (lenReg == '0) |=> outTrap == TRAP_SEG);

  // R5: a bad segment wins over any limit result
  a_r5_seg_priority: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !segInRange |=> outTrap == TRAP_SEG);

  // R4: in-range segment with displacement at or past its limit
  a_r4_over_limit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && segInRange && !dispInLimit |=> outTrap == TRAP_LIMIT);

  // R7: trapped results never carry an address
  a_r7_trap_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (outTrap != TRAP_NONE) |-> outPaddr == '0);

  // R7: code 3 is never produced
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    outTrap != 2'd3);

endmodule

// File: rtl/seg_control.sv
module seg_control
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEntryWe,
  input  logic        cfgLenWe,
  input  logic        reqValid,
  input  logic        segInRange,
  input  logic        dispInLimit,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.tblWrite = cfgEntryWe;
    strobe.lenWrite = cfgLenWe;
    strobe.capture  = reqValid;
    if (!segInRange)       strobe.trapSel = TRAP_SEG;
    else if (!dispInLimit) strobe.trapSel = TRAP_LIMIT;
    else                   strobe.trapSel = TRAP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

  // R2: every request produces a result strobe next cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R2: no result strobe without a request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

endmodule

// File: rtl/seg_translator.sv
module seg_translator
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int DISP_W = 16,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEntryWe,
  input  logic [SEG_W-1:0]  cfgIdx,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [LIM_W-1:0]  cfgLimit,
  input  logic              cfgLenWe,
  input  logic [SEG_W:0]    cfgLen,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [DISP_W-1:0] reqDisp,
  output logic              outValid,
  output logic [BASE_W-1:0] outPaddr,
  output logic [1:0]        outTrap
);
  ctrlStrobe_t strobe;
  logic        segInRange;
  logic        dispInLimit;

  seg_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEntryWe (cfgEntryWe),
    .cfgLenWe   (cfgLenWe),
    .reqValid   (reqValid),
    .segInRange (segInRange),
    .dispInLimit(dispInLimit),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  seg_datapath #(
    .SEG_W (SEG_W),
    .DISP_W(DISP_W),
    .BASE_W(BASE_W),
    .LIM_W (LIM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgIdx     (cfgIdx),
    .cfgBase    (cfgBase),
    .cfgLimit   (cfgLimit),
    .cfgLen     (cfgLen),
    .reqSeg     (reqSeg),
    .reqDisp    (reqDisp),
    .segInRange (segInRange),
    .dispInLimit(dispInLimit),
    .outPaddr   (outPaddr),
    .outTrap    (outTrap)
  );

endmodule

// File: tb/tb_seg_translator.sv
module tb_seg_translator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEntryWe = 1'b0;
  logic [7:0]  cfgIdx = '0;
  logic [23:0] cfgBase = '0;
  logic [16:0] cfgLimit = '0;
  logic        cfgLenWe = 1'b0;
  logic [8:0]  cfgLen = '0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqSeg = '0;
  logic [15:0] reqDisp = '0;
  logic        outValid;
  logic [23:0] outPaddr;
  logic [1:0]  outTrap;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_translator dut (
    .clk(clk), .rstN(rstN),
    .cfgEntryWe(cfgEntryWe), .cfgIdx(cfgIdx), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .cfgLenWe(cfgLenWe), .cfgLen(cfgLen),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqDisp(reqDisp),
    .outValid(outValid), .outPaddr(outPaddr), .outTrap(outTrap)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input int base, input int lim);
    @(negedge clk);
    cfgEntryWe = 1'b1; cfgIdx = 8'(idx); cfgBase = 24'(base); cfgLimit = 17'(lim);
    @(negedge clk);
    cfgEntryWe = 1'b0;
  endtask

  task automatic writeLen(input int len);
    @(negedge clk);
    cfgLenWe = 1'b1; cfgLen = 9'(len);
    @(negedge clk);
    cfgLenWe = 1'b0;
  endtask

  // one request; result checked at the next falling edge
  task automatic xlate(input int seg, input int disp, input int expTrap,
                       input int expAddr, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 8'(seg); reqDisp = 16'(disp);
    @(negedge clk);
    reqValid = 1'b0;
    check(outValid == 1'b1, {tag, " valid"}, outValid, 1);
    check(outTrap == 2'(expTrap), {tag, " trap"}, outTrap, expTrap);
    check(outPaddr == 24'(expAddr), {tag, " addr"}, outPaddr, expAddr);
  endtask

  task automatic t_reset;
    check(outValid == 1'b0, "R1 reset valid", outValid, 0);
    check(outTrap == 2'd0, "R1 reset trap", outTrap, 0);
    check(outPaddr == 24'd0, "R1 reset addr", outPaddr, 0);
    xlate(0, 0, 1, 0, "R1 empty table");
  endtask

  task automatic t_example;
    writeEntry(0, 1400, 1000);
    writeEntry(1, 6300, 400);
    writeEntry(2, 4300, 400);
    writeEntry(3, 3200, 1100);
    writeEntry(4, 4700, 1000);
    writeLen(5);
    xlate(2, 53, 0, 4353, "R6 seg2");
    xlate(3, 852, 0, 4052, "R6 seg3");
    xlate(0, 1222, 2, 0, "R4 R7 seg0 over");
  endtask

  task automatic t_limitEdge;
    xlate(2, 399, 0, 4699, "R4 limit-1");
    xlate(2, 400, 2, 0, "R4 at limit");
  endtask

  task automatic t_badSeg;
    xlate(5, 0, 1, 0, "R3 seg=len");
    xlate(200, 10, 1, 0, "R3 seg far");
  endtask

  task automatic t_priority;
    xlate(7, 60000, 1, 0, "R5 both fail");
  endtask

  task automatic t_wrap;
    writeEntry(5, 24'hFFFFF0, 17'h10000);
    writeEntry(6, 8, 0);
    writeLen(7);
    xlate(5, 16'h20, 0, 24'h000010, "R6 wrap");
    xlate(5, 16'hFFFF, 0, 24'h00FFEF, "R6 wrap max");
    xlate(6, 0, 2, 0, "R4 zero limit");
  endtask

  task automatic t_sameCycle;
    // entry write shares the cycle with a request
    @(negedge clk);
    cfgEntryWe = 1'b1; cfgIdx = 8'd2; cfgBase = 24'd100; cfgLimit = 17'd50;
    reqValid = 1'b1; reqSeg = 8'd2; reqDisp = 16'd10;
    @(negedge clk);
    cfgEntryWe = 1'b0; reqValid = 1'b0;
    check(outTrap == 2'd0 && outPaddr == 24'd4310, "R8 old entry", outPaddr, 4310);
    xlate(2, 10, 0, 110, "R8 new entry");
    // length write shares the cycle with a request
    @(negedge clk);
    cfgLenWe = 1'b1; cfgLen = 9'd0;
    reqValid = 1'b1; reqSeg = 8'd1; reqDisp = 16'd5;
    @(negedge clk);
    cfgLenWe = 1'b0; reqValid = 1'b0;
    check(outTrap == 2'd0 && outPaddr == 24'd6305, "R8 old length", outPaddr, 6305);
    xlate(1, 5, 1, 0, "R8 new length");
  endtask

  task automatic t_lastIdx;
    writeEntry(255, 24'h123456, 1);
    writeLen(256);
    xlate(255, 0, 0, 24'h123456, "R9 last entry");
    xlate(255, 1, 2, 0, "R9 last over");
  endtask

  task automatic t_backToBack;
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 8'd3; reqDisp = 16'd0;
    @(negedge clk);
    reqSeg = 8'd4; reqDisp = 16'd1;
    check(outValid && outPaddr == 24'd3200, "R2 first of pair", outPaddr, 3200);
    @(negedge clk);
    reqValid = 1'b0;
    check(outValid && outPaddr == 24'd4701, "R2 second of pair", outPaddr, 4701);
    @(negedge clk);
    check(outValid == 1'b0, "R2 idle", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R2 idle again", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_example();
    t_limitEdge();
    t_badSeg();
    t_priority();
    t_wrap();
    t_sameCycle();
    t_lastIdx();
    t_backToBack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule